// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits between a group of interrupt sources and the interrupt input of a processor core. Each cycle it masks the raw request lines with a per-source enable bit and picks the most urgent survivor: the lowest-numbered enabled pending source wins. It then reads that source's entry from a small writable table. Each entry holds a handler address and a register-bank select. The chosen index and the table read are captured in registers, so none of this logic sits on the core's own timing paths.

The core sees a single interrupt line. When it takes the interrupt it pulses acknowledge. On that pulse the block latches the handler address, which replaces the fixed interrupt vector, and the bank select, which picks the register file the handler runs on. Both stay frozen until the next accepted acknowledge, so the values cannot shift while the core is entering the handler. Software loads the table through a one-entry-per-cycle write port.

Top module: `vic_ctrl`

## Requirements
- R1: While reset is asserted, and for two cycles after it is released, `irq_o` is 0, `vec_o` is 0 and `bank_o` is 0. Every table entry resets to disabled, with address 0 and bank 0.
- R2: After each rising clock edge, `irq_o` is 1 if and only if, at that edge, at least one source had its `req_i` bit set and its table entry enabled.
- R3: A source whose entry has its enable bit at 0 is ignored. It neither raises `irq_o` nor wins arbitration, whatever its request bit.
- R4: When several enabled sources request at once, the one with the smallest index (bit 0 of `req_i` is source 0) is selected.
- R5: On a clock edge where `ack_i` is 1 and `irq_o` is 1, `vec_o` and `bank_o` load the address and bank of the entry selected at the previous edge. That is the table content as it stood at that previous edge.
- R6: `vec_o` and `bank_o` change only on an accepted acknowledge. Changes to requests or to table contents leave them unchanged in between.
- R7: An `ack_i` pulse while `irq_o` is 0 has no effect on `vec_o` or `bank_o`.
- R8: A table write is made by setting `tbl_we_i` with `tbl_sel_i` naming the entry and `tbl_vec_i`, `tbl_bank_i`, `tbl_en_i` as the new fields. It is stored at that edge and first affects arbitration at the following edge. Arbitration at the write edge itself uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 8 | Request line per source, bit n is source n |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_sel_i | input | 3 | Entry index to write |
| tbl_vec_i | input | 32 | Handler address to store |
| tbl_bank_i | input | 4 | Register-bank select to store |
| tbl_en_i | input | 1 | Enable bit to store |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 32 | Latched handler address |
| bank_o | output | 4 | Latched register-bank select |

## Verification
The assertions assume that `req_i` and the table write inputs hold known values at every clock edge after reset. They also assume that `ack_i` is a level sampled at the edge, not a pulse that must be caught between edges. The bench changes every input only on the falling clock edge and holds requests at 0 through reset and the synchronizer delay. It sweeps all 256 request patterns under several enable masks, asserting acknowledge both with and without a pending interrupt.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_NUM_SRC = 8;
  localparam int unsigned VIC_VEC_W   = 32;
  localparam int unsigned VIC_BANK_W  = 4;
  localparam int unsigned VIC_SRC_W   = $clog2(VIC_NUM_SRC);

  typedef enum logic [1:0] {
    OUT_HOLD  = 2'b00,
    OUT_LOAD  = 2'b01
  } out_act_e;
endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/vic_table.sv
module vic_table #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned BANK_W  = 4,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SRC_W-1:0]  sel_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              en_i,
  output logic [NUM_SRC-1:0] en_mask_o,
  output logic [VEC_W-1:0]  ent_vec_o  [NUM_SRC],
  output logic [BANK_W-1:0] ent_bank_o [NUM_SRC]
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    logic              hit;
    logic [VEC_W-1:0]  vec_q,  vec_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic              en_q,   en_d;

    always_comb begin
      hit    = we_i && (sel_i == SRC_W'(g));
      vec_d  = hit ? vec_i  : vec_q;
      bank_d = hit ? bank_i : bank_q;
      en_d   = hit ? en_i   : en_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_q  <= '0;
        bank_q <= '0;
        en_q   <= 1'b0;
      end else begin
        vec_q  <= vec_d;
        bank_q <= bank_d;
        en_q   <= en_d;
      end
    end

    assign en_mask_o[g]  = en_q;
    assign ent_vec_o[g]  = vec_q;
    assign ent_bank_o[g] = bank_q;
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [SRC_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] seen;
  logic [NUM_SRC-1:0] onehot;

  assign seen[0]   = 1'b0;
  assign onehot[0] = pend_i[0];
  for (genvar g = 1; g < NUM_SRC; g++) begin : g_chain
    assign seen[g]   = seen[g-1] | pend_i[g-1];
    assign onehot[g] = pend_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      idx_o = idx_o | (onehot[i] ? SRC_W'(i) : '0);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = VIC_NUM_SRC,
  parameter int unsigned VEC_W   = VIC_VEC_W,
  parameter int unsigned BANK_W  = VIC_BANK_W,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               tbl_we_i,
  input  logic [SRC_W-1:0]   tbl_sel_i,
  input  logic [VEC_W-1:0]   tbl_vec_i,
  input  logic [BANK_W-1:0]  tbl_bank_i,
  input  logic               tbl_en_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [BANK_W-1:0]  bank_o
);
  logic rst_sync_n;

  vic_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  logic [NUM_SRC-1:0] tbl_en_mask;
  logic [VEC_W-1:0]   ent_vec  [NUM_SRC];
  logic [BANK_W-1:0]  ent_bank [NUM_SRC];

  vic_table #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .BANK_W(BANK_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .we_i      (tbl_we_i),
    .sel_i     (tbl_sel_i),
    .vec_i     (tbl_vec_i),
    .bank_i    (tbl_bank_i),
    .en_i      (tbl_en_i),
    .en_mask_o (tbl_en_mask),
    .ent_vec_o (ent_vec),
    .ent_bank_o(ent_bank)
  );

  logic [NUM_SRC-1:0] pend;
  logic               win_any;
  logic [SRC_W-1:0]   win_idx;

  assign pend = req_i & tbl_en_mask;

  vic_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .pend_i(pend),
    .any_o (win_any),
    .idx_o (win_idx)
  );

  // Arbitration stage: winner and its entry are registered.
  logic              irq_q,      irq_d;
  logic [VEC_W-1:0]  cand_vec_q, cand_vec_d;
  logic [BANK_W-1:0] cand_bank_q, cand_bank_d;

  always_comb begin
    irq_d       = win_any;
    cand_vec_d  = ent_vec[win_idx];
    cand_bank_d = ent_bank[win_idx];
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q       <= 1'b0;
      cand_vec_q  <= '0;
      cand_bank_q <= '0;
    end else begin
      irq_q       <= irq_d;
      cand_vec_q  <= cand_vec_d;
      cand_bank_q <= cand_bank_d;
    end
  end

  // Output stage: frozen except on an accepted acknowledge.
  out_act_e          out_act;
  logic [VEC_W-1:0]  vec_q,  vec_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    out_act = (ack_i && irq_q) ? OUT_LOAD : OUT_HOLD;
    vec_d   = vec_q;
    bank_d  = bank_q;
    if (out_act == OUT_LOAD) begin
      vec_d  = cand_vec_q;
      bank_d = cand_bank_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q  <= '0;
      bank_q <= '0;
    end else begin
      vec_q  <= vec_d;
      bank_q <= bank_d;
    end
  end

  assign irq_o  = irq_q;
  assign vec_o  = vec_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned BANK_W  = 4
) (
  input logic               clk_i,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] en_mask,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [BANK_W-1:0]  bank_o
);
  // R1: outputs cleared while the internal reset is held
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_sync_n |-> (!irq_o && vec_o == '0 && bank_o == '0));

  // R2 / R3: interrupt line tracks enabled pending sources one edge later
  a_r2_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> (irq_o == $past(|(req_i & en_mask))));

  // R6: no acknowledge, no change
  a_r6_hold_no_ack: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !ack_i |=> ($stable(vec_o) && $stable(bank_o)));

  // R7: acknowledge without pending interrupt is ignored
  a_r7_idle_ack: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ack_i && !irq_o) |=> ($stable(vec_o) && $stable(bank_o)));

  // R5: any output change is preceded by an accepted acknowledge
  a_r5_change_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!$stable(vec_o) || !$stable(bank_o)) |-> $past(ack_i && irq_o));
endmodule

bind vic_ctrl vic_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .BANK_W(BANK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_sync_n(rst_sync_n),
  .req_i     (req_i),
  .en_mask   (tbl_en_mask),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .bank_o    (bank_o)
);

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
  localparam int NS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  req_i;
  logic        tbl_we_i;
  logic [2:0]  tbl_sel_i;
  logic [31:0] tbl_vec_i;
  logic [3:0]  tbl_bank_i;
  logic        tbl_en_i;
  logic        ack_i;
  logic        irq_o;
  logic [31:0] vec_o;
  logic [3:0]  bank_o;

  always #4 clk_i = ~clk_i;

  vic_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .tbl_we_i(tbl_we_i), .tbl_sel_i(tbl_sel_i), .tbl_vec_i(tbl_vec_i),
    .tbl_bank_i(tbl_bank_i), .tbl_en_i(tbl_en_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o), .bank_o(bank_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_vec  [NS];
  logic [3:0]  m_bank [NS];
  logic [7:0]  m_en;
  logic [31:0] e_vec;
  logic [3:0]  e_bank;

  function automatic logic [31:0] vec_of(int i, int salt);
    return 32'hC000_0000 + 32'(i) * 32'h0101_0010 + 32'(salt) * 32'h0000_1000;
  endfunction

  function automatic logic [3:0] bank_of(int i, int salt);
    return 4'((i * 3 + 1 + salt) % 16);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] v, input logic [3:0] b, input logic e);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_sel_i = 3'(i); tbl_vec_i = v; tbl_bank_i = b; tbl_en_i = e;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    m_vec[i] = v; m_bank[i] = b; m_en[i] = e;
  endtask

  task automatic load_mask(input logic [7:0] mask, input int salt);
    for (int i = 0; i < NS; i++) wr(i, vec_of(i, salt), bank_of(i, salt), mask[i]);
  endtask

  // One arbitration + acknowledge round under request pattern r.
  task automatic round(input logic [7:0] r);
    logic [7:0] p;
    int w;
    @(negedge clk_i);
    req_i = r; ack_i = 1'b0;
    @(negedge clk_i);
    p = r & m_en;
    check(irq_o == (p != 0), "R2/R3 irq", 32'(irq_o), 32'(p != 0));
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    if (p != 0) begin
      w = -1;
      for (int i = NS - 1; i >= 0; i--) if (p[i]) w = i;
      e_vec = m_vec[w]; e_bank = m_bank[w];
      check(vec_o == e_vec, "R4/R5 vec", vec_o, e_vec);
      check(bank_o == e_bank, "R4/R5 bank", 32'(bank_o), 32'(e_bank));
    end else begin
      check(vec_o == e_vec && bank_o == e_bank, "R7 idle ack", vec_o, e_vec);
    end
  endtask

  initial begin
    rst_ni = 1'b0; req_i = '0; ack_i = 1'b0; tbl_we_i = 1'b0;
    tbl_sel_i = '0; tbl_vec_i = '0; tbl_bank_i = '0; tbl_en_i = 1'b0;
    m_en = '0; e_vec = '0; e_bank = '0;
    for (int i = 0; i < NS; i++) begin m_vec[i] = '0; m_bank[i] = '0; end
    repeat (3) @(negedge clk_i);
    check(irq_o == 1'b0 && vec_o == '0 && bank_o == '0, "R1 in reset", vec_o, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(irq_o == 1'b0 && vec_o == '0 && bank_o == '0, "R1 after release", vec_o, 32'h0);

    // R1: all entries disabled after reset, requests raise nothing
    req_i = 8'hFF;
    @(negedge clk_i); @(negedge clk_i);
    check(irq_o == 1'b0, "R1 table disabled", 32'(irq_o), 32'h0);
    req_i = '0;

    // Exhaustive request sweep under several enable masks (R2 R3 R4 R5 R7)
    begin
      logic [7:0] masks [5];
      masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'hAA;
      masks[3] = 8'h5A; masks[4] = 8'h81;
      for (int k = 0; k < 5; k++) begin
        load_mask(masks[k], k);
        for (int r = 0; r < 256; r++) round(8'(r));
      end
    end

    // R6: captured values survive request and table changes without ack
    load_mask(8'hFF, 7);
    round(8'h24);
    wr(2, 32'hDEAD_0002, 4'hE, 1'b1);
    @(negedge clk_i);
    req_i = 8'h01;
    repeat (5) @(negedge clk_i);
    check(vec_o == e_vec, "R6 hold vec", vec_o, e_vec);
    check(bank_o == e_bank, "R6 hold bank", 32'(bank_o), 32'(e_bank));

    // R8: a write is not seen at its own edge, only at the next
    wr(0, 32'h1234_5678, 4'h3, 1'b0);
    req_i = 8'h01;
    repeat (2) @(negedge clk_i);
    check(irq_o == 1'b0, "R8 disabled before", 32'(irq_o), 32'h0);
    tbl_we_i = 1'b1; tbl_sel_i = 3'd0; tbl_vec_i = 32'h1234_5678;
    tbl_bank_i = 4'h3; tbl_en_i = 1'b1;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    check(irq_o == 1'b0, "R8 same edge old entry", 32'(irq_o), 32'h0);
    @(negedge clk_i);
    check(irq_o == 1'b1, "R8 next edge new entry", 32'(irq_o), 32'h1);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    check(vec_o == 32'h1234_5678, "R8 new vec", vec_o, 32'h1234_5678);
    check(bank_o == 4'h3, "R8 new bank", 32'(bank_o), 32'h3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule